// File: doc/BRIEF.md
# 64-Source Prioritised Interrupt Controller

This block collects 64 interrupt request lines, decides which one the CPU should service next and drives a single interrupt line toward the CPU. Software talks to it through a simple 32-bit register bus with separate read and write strobes. Each source has a setup word that selects edge or level detection and assigns a 3-bit priority. A 64-bit enable mask is changed through write-one-to-set and write-one-to-clear strobe registers, one pair for sources 0..31 and one pair for sources 32..63.

Request inputs pass through a two-stage synchroniser. A level source is pending while its synchronised input is high. An edge source latches a pending flag on a rising edge and keeps it until the source is serviced. Reading the vector register returns the winning source and puts it in service. While a source is in service, only requests with a strictly higher priority can raise the interrupt line again. A write to the end-of-interrupt register ends the service and clears that source's edge latch. A global generation enable gates the output. A soft-reset bit clears every register.

Address map (byte addresses, 12-bit bus): setup words at 0x000 + 8*n, enable-set low/high at 0x200/0x204, enable-clear low/high at 0x208/0x20C, mask readback low/high at 0x220/0x224, vector at 0x230, end-of-interrupt at 0x234, soft reset at 0x238, generation enable at 0x23C.

Top module: `irq_ctrl64`

## Requirements
- R1: A write to 0x200 sets mask bit i for every one in data bit i (source i). A write to 0x204 does the same for source 32+i. Zero data bits leave their mask bits unchanged. The mask reads back at 0x220 (sources 0..31) and 0x224 (sources 32..63).
- R2: A write to 0x208 clears mask bit i for every one in data bit i (source i). A write to 0x20C does the same for source 32+i. Zero data bits leave their mask bits unchanged.
- R3: Source n has a read/write setup word at byte address 8*n. Bit 8 is the edge select (1 = edge, 0 = level) and bits [2:0] are the priority, with 7 the highest. All other bits, and the word at 8*n+4, read as zero.
- R4: A level source is pending exactly while its synchronised input is high. It stops requesting once the input falls.
- R5: An edge source latches a pending flag on a rising edge of its synchronised input. The flag stays set after the input falls. It is latched even while the source is masked.
- R6: Among pending, enabled sources, the one with the highest priority wins. On equal priority the lowest source number wins.
- R7: A read of 0x230 returns the winning source number on bus_rdata in the cycle after the read strobe. It returns 64 when no eligible source is pending.
- R8: A vector read that returns a valid source puts that source and its priority in service. While a source is in service, sources at or below that priority neither raise irq_o nor appear in the vector, and higher-priority sources still do.
- R9: Any write to 0x234 ends the service and clears the edge latch of the serviced source.
- R10: irq_o is high only while the generation-enable bit (0x23C bit 0, readable) is set and an eligible source is pending. It follows the internal state with one register stage.
- R11: While a source's edge select is 0 its edge latch is held clear. Rewriting the setup word to level and back to edge therefore discards a latched edge.
- R12: A write of data bit 0 = 1 to 0x238 clears the setup words, mask, generation enable, edge latches, service state and synchroniser.
- R13: The write-only strobe addresses (0x200..0x20C, 0x234, 0x238) read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 64 | Interrupt request inputs, asynchronous |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 12 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| irq_o | output | 1 | Interrupt request to the CPU |

## Verification
The bound checker watches, on every cycle, the effect of each mask strobe on the mask state and that irq_o never rises without the generation enable. It also checks that a soft reset empties mask, enable and service state, that a vector read never returns more than 64, that a valid vector starts a service, that end-of-interrupt ends it, and that strobe addresses read as zero. Priority order, tie breaking, edge latching while masked, holding off requests during service, preemption by a higher priority and discarding an edge through the setup toggle are only visible through the directed scenarios, which read the vector at chosen moments and compare it with the expected source.

// File: rtl/irq_ctrl64_pkg.sv
package irq_ctrl64_pkg;
    localparam int SRC_N    = 64;
    localparam int HALF_N   = SRC_N / 2;
    localparam int ID_W     = $clog2(SRC_N) + 1;
    localparam int IDX_W    = $clog2(SRC_N);
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int EDGE_BIT = 8;
    localparam int SETUP_SPAN = SRC_N * 8;

    localparam logic [ADDR_W-1:0] A_ENA_LO  = 12'h200;
    localparam logic [ADDR_W-1:0] A_ENA_HI  = 12'h204;
    localparam logic [ADDR_W-1:0] A_DIS_LO  = 12'h208;
    localparam logic [ADDR_W-1:0] A_DIS_HI  = 12'h20C;
    localparam logic [ADDR_W-1:0] A_MASK_LO = 12'h220;
    localparam logic [ADDR_W-1:0] A_MASK_HI = 12'h224;
    localparam logic [ADDR_W-1:0] A_VEC     = 12'h230;
    localparam logic [ADDR_W-1:0] A_EOI     = 12'h234;
    localparam logic [ADDR_W-1:0] A_RST     = 12'h238;
    localparam logic [ADDR_W-1:0] A_GEN     = 12'h23C;
endpackage

// File: rtl/irq_ctrl64_sync.sv
module irq_ctrl64_sync #(
    parameter int WIDTH  = 64,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   chain_q[0] <= '0;
        else if (clr) chain_q[0] <= '0;
        else          chain_q[0] <= d;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   chain_q[g] <= '0;
            else if (clr) chain_q[g] <= '0;
            else          chain_q[g] <= chain_q[g-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/irq_ctrl64_psel.sv
module irq_ctrl64_psel #(
    parameter int N      = 64,
    parameter int PRIO_W = 3,
    parameter int ID_W   = 7
) (
    input  logic [N-1:0]             req,
    input  logic [N-1:0][PRIO_W-1:0] prio,
    output logic                     found,
    output logic [ID_W-1:0]          win_id,
    output logic [PRIO_W-1:0]        win_prio
);
    // Scan from the top index down; ">=" lets a lower index take over on ties.
    always_comb begin
        found    = 1'b0;
        win_id   = ID_W'(N);
        win_prio = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i] && (!found || prio[i] >= win_prio)) begin
                found    = 1'b1;
                win_id   = ID_W'(i);
                win_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/irq_ctrl64.sv
module irq_ctrl64
    import irq_ctrl64_pkg::*;
#(
    parameter int PRIO_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SRC_N-1:0]     src_i,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_o
);
    typedef struct packed {
        logic [SRC_N-1:0]             edge_cfg;
        logic [SRC_N-1:0][PRIO_W-1:0] prio;
        logic [SRC_N-1:0]             mask;
        logic                         gen;
        logic [SRC_N-1:0]             latch;
        logic [SRC_N-1:0]             prev;
        logic                         isr_vld;
        logic [ID_W-1:0]              isr_id;
        logic [PRIO_W-1:0]            isr_prio;
        logic                         irq;
        logic [DATA_W-1:0]            rdata;
    } state_t;

    state_t s_d, s_q;

    logic [SRC_N-1:0]  sync_q;
    logic [SRC_N-1:0]  pending, above, req;
    logic              found;
    logic [ID_W-1:0]   win_id;
    logic [PRIO_W-1:0] win_prio;
    logic              soft_rst;
    logic              in_setup;
    logic [IDX_W-1:0]  sel_idx;
    logic [SRC_N-1:0]  rise;

    assign soft_rst = bus_wr && (bus_addr == A_RST) && bus_wdata[0];
    assign in_setup = (bus_addr < ADDR_W'(SETUP_SPAN)) && (bus_addr[2:0] == 3'b000);
    assign sel_idx  = bus_addr[IDX_W+2:3];

    irq_ctrl64_sync #(.WIDTH(SRC_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .d(src_i), .q(sync_q)
    );

    // Eligibility: pending, enabled and above the priority in service.
    always_comb begin
        pending = s_q.latch | (sync_q & ~s_q.edge_cfg);
        for (int i = 0; i < SRC_N; i++) begin
            above[i] = !s_q.isr_vld || (s_q.prio[i] > s_q.isr_prio);
        end
        req = pending & s_q.mask & above;
    end

    irq_ctrl64_psel #(.N(SRC_N), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_psel (
        .req(req), .prio(s_q.prio), .found(found), .win_id(win_id), .win_prio(win_prio)
    );

    always_comb begin
        s_d      = s_q;
        rise     = sync_q & ~s_q.prev;
        s_d.prev = sync_q;

        // Read side: data is registered; a valid vector read starts service.
        if (bus_rd) begin
            s_d.rdata = '0;
            if (in_setup) begin
                s_d.rdata[EDGE_BIT]     = s_q.edge_cfg[sel_idx];
                s_d.rdata[PRIO_W-1:0]   = s_q.prio[sel_idx];
            end else begin
                case (bus_addr)
                    A_MASK_LO: s_d.rdata = s_q.mask[HALF_N-1:0];
                    A_MASK_HI: s_d.rdata = s_q.mask[SRC_N-1:HALF_N];
                    A_GEN:     s_d.rdata[0] = s_q.gen;
                    A_VEC: begin
                        s_d.rdata = found ? DATA_W'(win_id) : DATA_W'(SRC_N);
                        if (found) begin
                            s_d.isr_vld  = 1'b1;
                            s_d.isr_id   = win_id;
                            s_d.isr_prio = win_prio;
                        end
                    end
                    default: ;
                endcase
            end
        end

        // Write side.
        s_d.latch = s_q.latch;
        if (bus_wr) begin
            if (in_setup) begin
                s_d.edge_cfg[sel_idx] = bus_wdata[EDGE_BIT];
                s_d.prio[sel_idx]     = bus_wdata[PRIO_W-1:0];
            end else begin
                case (bus_addr)
                    A_ENA_LO: s_d.mask[HALF_N-1:0]     = s_q.mask[HALF_N-1:0] | bus_wdata;
                    A_ENA_HI: s_d.mask[SRC_N-1:HALF_N] = s_q.mask[SRC_N-1:HALF_N] | bus_wdata;
                    A_DIS_LO: s_d.mask[HALF_N-1:0]     = s_q.mask[HALF_N-1:0] & ~bus_wdata;
                    A_DIS_HI: s_d.mask[SRC_N-1:HALF_N] = s_q.mask[SRC_N-1:HALF_N] & ~bus_wdata;
                    A_GEN:    s_d.gen = bus_wdata[0];
                    A_EOI: begin
                        if (s_q.isr_vld) begin
                            s_d.latch[s_q.isr_id[IDX_W-1:0]] = 1'b0;
                        end
                        s_d.isr_vld = 1'b0;
                    end
                    default: ;
                endcase
            end
        end

        // Edge latching; a new edge wins over a same-cycle clear.
        s_d.latch = (s_d.latch | rise) & s_d.edge_cfg;

        s_d.irq = s_q.gen && found;

        if (soft_rst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rdata = s_q.rdata;
    assign irq_o     = s_q.irq;
endmodule

// File: rtl/irq_ctrl64_chk.sv
module irq_ctrl64_chk
    import irq_ctrl64_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              irq_o,
    input logic              gen_q,
    input logic [SRC_N-1:0]  mask_q,
    input logic              isr_vld_q
);
    // R1
    ena_lo_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ENA_LO) |=>
        ((mask_q[HALF_N-1:0] & $past(bus_wdata)) == $past(bus_wdata)));
    // R1
    ena_hi_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_ENA_HI) |=>
        ((mask_q[SRC_N-1:HALF_N] & $past(bus_wdata)) == $past(bus_wdata)));
    // R2
    dis_lo_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DIS_LO) |=>
        ((mask_q[HALF_N-1:0] & $past(bus_wdata)) == '0));
    // R2
    dis_hi_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_DIS_HI) |=>
        ((mask_q[SRC_N-1:HALF_N] & $past(bus_wdata)) == '0));
    // R10
    irq_needs_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(gen_q));
    // R12
    soft_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_RST && bus_wdata[0]) |=>
        (mask_q == '0 && !gen_q && !isr_vld_q));
    // R7
    vector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_VEC) |=> (bus_rdata <= DATA_W'(SRC_N)));
    // R8
    vector_starts_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == A_VEC) |=>
        (bus_rdata == DATA_W'(SRC_N) || isr_vld_q));
    // R9
    eoi_ends_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && bus_addr == A_EOI) |=> !isr_vld_q);
    // R13
    strobe_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == A_ENA_LO || bus_addr == A_ENA_HI ||
                    bus_addr == A_DIS_LO || bus_addr == A_DIS_HI ||
                    bus_addr == A_EOI || bus_addr == A_RST)) |=> (bus_rdata == '0));
endmodule

bind irq_ctrl64 irq_ctrl64_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .gen_q(s_q.gen), .mask_q(s_q.mask), .isr_vld_q(s_q.isr_vld)
);

// File: tb/test_irq_ctrl64.sv
`timescale 1ns/1ps
module test_irq_ctrl64;
    import irq_ctrl64_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [SRC_N-1:0]  src_i = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    irq_ctrl64 i_irq_ctrl64 (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        src_i[idx] = 1'b1;
        repeat (2) @(negedge clk);
        src_i[idx] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R12 irq after reset", 32'(irq_o), 32'd0);
        rd(A_VEC, v);      check("R7 vector empty", v, 32'd64);
        rd(A_MASK_LO, v);  check("R12 mask low after reset", v, 32'd0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(A_ENA_LO, 32'h0000_00F0); rd(A_MASK_LO, v); check("R1 set low", v, 32'h0000_00F0);
        wr(A_ENA_LO, 32'h0000_0100); rd(A_MASK_LO, v); check("R1 zero bits keep", v, 32'h0000_01F0);
        wr(A_DIS_LO, 32'h0000_0010); rd(A_MASK_LO, v); check("R2 clear low", v, 32'h0000_01E0);
        wr(A_ENA_HI, 32'h8000_0001); rd(A_MASK_HI, v); check("R1 set high", v, 32'h8000_0001);
        wr(A_DIS_HI, 32'h0000_0001); rd(A_MASK_HI, v); check("R2 clear high", v, 32'h8000_0000);
        rd(A_MASK_LO, v); check("R2 high clear leaves low", v, 32'h0000_01E0);
        rd(A_ENA_LO, v);  check("R13 strobe reads zero", v, 32'd0);
        rd(A_DIS_HI, v);  check("R13 strobe reads zero", v, 32'd0);
        wr(A_DIS_LO, 32'hFFFF_FFFF); wr(A_DIS_HI, 32'hFFFF_FFFF);
        rd(A_MASK_HI, v); check("R2 all cleared", v, 32'd0);
    endtask

    task automatic t_setup();
        logic [31:0] v;
        wr(12'h1F8, 32'hFFFF_0105); rd(12'h1F8, v); check("R3 setup 63", v, 32'h0000_0105);
        wr(12'h028, 32'h0000_0002); rd(12'h028, v); check("R3 setup 5", v, 32'h0000_0002);
        rd(12'h1FC, v); check("R3 stride gap", v, 32'd0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(A_ENA_LO, 32'h0000_0020);
        wr(A_GEN, 32'h1);
        rd(A_GEN, v); check("R10 gen readback", v, 32'd1);
        src_i[5] = 1'b1; idle(6);
        check("R4 level raises irq", 32'(irq_o), 32'd1);
        wr(A_GEN, 32'h0); idle(3);
        check("R10 gen off blocks irq", 32'(irq_o), 32'd0);
        wr(A_GEN, 32'h1); idle(3);
        check("R10 gen on restores irq", 32'(irq_o), 32'd1);
        src_i[5] = 1'b0; idle(6);
        check("R4 level falls", 32'(irq_o), 32'd0);
        rd(A_VEC, v); check("R4 vector empty after fall", v, 32'd64);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        wr(12'h018, 32'h0000_0101);    // source 3: edge, prio 1
        wr(12'h050, 32'h0000_0105);    // source 10: edge, prio 5
        wr(12'h140, 32'h0000_0105);    // source 40: edge, prio 5
        wr(A_ENA_LO, 32'h0000_0408);
        wr(A_ENA_HI, 32'h0000_0100);
        @(negedge clk);
        src_i[3] = 1'b1; src_i[10] = 1'b1; src_i[40] = 1'b1;
        repeat (2) @(negedge clk);
        src_i[3] = 1'b0; src_i[10] = 1'b0; src_i[40] = 1'b0;
        idle(6);
        check("R5 edges latched after input low", 32'(irq_o), 32'd1);
        rd(A_VEC, v); check("R6 tie goes to lowest index", v, 32'd10);
        idle(3);
        check("R8 equal and lower priority held", 32'(irq_o), 32'd0);
        rd(A_VEC, v); check("R8 vector hidden during service", v, 32'd64);
        wr(A_EOI, 32'h0); idle(3);
        check("R9 release after eoi", 32'(irq_o), 32'd1);
        rd(A_VEC, v); check("R9 serviced latch cleared", v, 32'd40);
        wr(A_EOI, 32'h0);
        rd(A_VEC, v); check("R6 lower priority last", v, 32'd3);
        wr(A_EOI, 32'h0);
        rd(A_VEC, v); check("R9 all latches cleared", v, 32'd64);
        idle(2);
        check("R9 irq idle", 32'(irq_o), 32'd0);
    endtask

    task automatic t_preempt();
        logic [31:0] v;
        src_i[5] = 1'b1; idle(6);
        rd(A_VEC, v); check("R8 level source serviced", v, 32'd5);
        idle(3);
        check("R8 own level held off", 32'(irq_o), 32'd0);
        wr(12'h0A0, 32'h0000_0007);    // source 20: level, prio 7
        wr(A_ENA_LO, 32'h0010_0000);
        src_i[20] = 1'b1; idle(6);
        check("R8 higher priority preempts", 32'(irq_o), 32'd1);
        rd(A_VEC, v); check("R8 preempting vector", v, 32'd20);
        src_i[20] = 1'b0; src_i[5] = 1'b0; idle(6);
        wr(A_EOI, 32'h0); idle(3);
        check("R9 idle after preempt", 32'(irq_o), 32'd0);
    endtask

    task automatic t_masked_edge();
        logic [31:0] v;
        pulse(63); idle(6);
        check("R5 masked edge no irq", 32'(irq_o), 32'd0);
        rd(A_VEC, v); check("R5 masked edge hidden", v, 32'd64);
        wr(A_ENA_HI, 32'h8000_0000); idle(3);
        check("R5 latched while masked", 32'(irq_o), 32'd1);
        rd(A_VEC, v); check("R5 masked edge vector", v, 32'd63);
        wr(A_EOI, 32'h0);
    endtask

    task automatic t_edge_toggle();
        logic [31:0] v;
        pulse(63); idle(6);
        check("R11 edge pending", 32'(irq_o), 32'd1);
        wr(12'h1F8, 32'h0000_0005);
        wr(12'h1F8, 32'h0000_0105);
        idle(3);
        check("R11 toggle drops irq", 32'(irq_o), 32'd0);
        rd(A_VEC, v); check("R11 toggle clears latch", v, 32'd64);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        pulse(63); idle(6);
        check("R12 pending before reset", 32'(irq_o), 32'd1);
        wr(A_RST, 32'h1); idle(3);
        check("R12 irq cleared", 32'(irq_o), 32'd0);
        rd(A_MASK_HI, v); check("R12 mask cleared", v, 32'd0);
        rd(12'h1F8, v);   check("R12 setup cleared", v, 32'd0);
        rd(A_GEN, v);     check("R12 gen cleared", v, 32'd0);
        rd(A_RST, v);     check("R13 reset strobe reads zero", v, 32'd0);
        rd(A_VEC, v);     check("R12 vector empty", v, 32'd64);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_mask();
        t_setup();
        t_level();
        t_prio();
        t_preempt();
        t_masked_edge();
        t_edge_toggle();
        t_soft_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule